// File: doc/BRIEF.md
# Sized Circular Event Buffer Manager

This block keeps the bookkeeping for a circular event log held in a memory that is split between the event log and a general-purpose user area. A 2-bit partition code picks how many event slots belong to the log; the rest of the memory goes to the user area, whose size the block reports in kilobytes. The block does not hold any event data. It supplies the slot address for the next stored event and the slot address for the next event to read back, and it counts how many events are held.

Readback can walk the log upward or downward through the slots. A read-only flag reports that the last read stepped across the edge of the log and the read pointer wrapped. Three occupancy alarms (half, three-quarter and full) can each be enabled separately. Each alarm latches when occupancy moves into its region. An active-low interrupt stays low while any alarm is latched, and software clears each alarm by writing a 1 to its bit.

Top module: `ebuf_mgr`

## Requirements
- R1: After reset both pointers and the count are 0, the partition code is 00 (capacity 4000), the user area reads 0, `rd_err` is 0, no alarm is latched and `irq_n` is 1.
- R2: Partition code 00, 01, 10 and 11 gives a capacity of 4000, 3000, 2000 and 1000 events and a user area of 0, 8, 16 and 24 KB.
- R3: A control write whose partition code differs from the current one clears both pointers, the count, `rd_err` and all latched alarms in the same cycle, and push or pop requests in that cycle are ignored. A control write with the current code leaves all of this state unchanged.
- R4: An accepted push raises the count by one and advances `wr_addr` by one. After slot capacity-1, `wr_addr` goes back to 0.
- R5: A push while the count equals the capacity is dropped: the count and `wr_addr` do not change.
- R6: An accepted pop lowers the count by one. With `ctl_dir`=0 the read pointer steps up and wraps from capacity-1 to 0. With `ctl_dir`=1 it steps down and wraps from 0 to capacity-1. A pop while the count is 0 has no effect.
- R7: `rd_err` goes to 1 on an accepted pop that wraps the read pointer. It goes back to 0 on the next accepted pop that does not wrap, or on a buffer reset. No input writes it.
- R8: Alarm bit 0 (half), bit 1 (three-quarter) and bit 2 (full) latch only when their enable bit is 1 and the count moves from below to at or above capacity/2, 3·capacity/4 (integer division) or capacity respectively. Staying in the region does not latch the bit again.
- R9: `irq_n` is 0 while any alarm bit is latched. Writing 1 to a bit of `irq_clr` clears that alarm in the next cycle.
- R10: A push and a pop accepted in the same cycle leave the count unchanged and move both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control write strobe (partition code and read direction) |
| ctl_size | input | 2 | Partition code written by `ctl_we` |
| ctl_dir | input | 1 | Read direction written by `ctl_we` (0 up, 1 down) |
| ien_we | input | 1 | Alarm-enable write strobe |
| ien_wdata | input | 3 | Alarm enables: bit0 half, bit1 three-quarter, bit2 full |
| irq_clr | input | 3 | Write-1-to-clear for the latched alarms |
| evt_push | input | 1 | An event is being stored |
| evt_pop | input | 1 | An event is being read out |
| wr_addr | output | 12 | Slot for the next stored event |
| rd_addr | output | 12 | Slot for the next event to read |
| fill | output | 12 | Number of events held |
| capacity | output | 12 | Event slots in the current partition |
| user_kb | output | 5 | User area size in KB |
| rd_err | output | 1 | Last accepted pop wrapped the read pointer |
| irq_pend | output | 3 | Latched alarms |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Every piece of state is visible at the ports one cycle after the edge that changes it. A wrong count shows up on `fill` immediately. It also shows up when an alarm latches one event early or late, or when a push at the limit is not dropped. A wrong pointer update shows up on `wr_addr` or `rd_addr`, and only later as a misplaced `rd_err` at the wrap. A partition change that fails to clear state leaves a nonzero count or a latched alarm visible in the cycle after the control write.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {
    RD_UP   = 1'b0,
    RD_DOWN = 1'b1
  } rd_dir_e;

  localparam int N_ALARM   = 3;
  localparam int AL_HALF   = 0;
  localparam int AL_3Q     = 1;
  localparam int AL_FULL   = 2;
endpackage

// File: rtl/ebuf_cfg.sv
module ebuf_cfg
  import ebuf_pkg::*;
#(
  parameter int MAX_EVENTS   = 4000,
  parameter int STEP_EVENTS  = 1000,
  parameter int USER_KB_STEP = 8,
  parameter int CW           = 12,
  parameter int KB_W         = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [1:0]         ctl_size,
  input  logic               ctl_dir,
  input  logic               ien_we,
  input  logic [N_ALARM-1:0] ien_wdata,
  output rd_dir_e            dir_q,
  output logic [N_ALARM-1:0] ien_q,
  output logic               buf_clr,
  output logic [CW-1:0]      cap,
  output logic [KB_W-1:0]    user_kb
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]         size_q, size_d;
  rd_dir_e            dir_d;
  logic [N_ALARM-1:0] ien_d;

  always_comb begin
    size_d  = size_q;
    dir_d   = dir_q;
    ien_d   = ien_q;
    buf_clr = 1'b0;
    if (ctl_we) begin
      size_d  = ctl_size;
      dir_d   = rd_dir_e'(ctl_dir);
      buf_clr = (ctl_size != size_q);
    end
    if (ien_we) ien_d = ien_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= 2'b00;
      dir_q  <= RD_UP;
      ien_q  <= '0;
    end else begin
      size_q <= size_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    cap     = CW'(MAX_EVENTS - int'(size_q) * STEP_EVENTS);
    user_kb = KB_W'(int'(size_q) * USER_KB_STEP);
  end

  p_cap_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_size == 2'b11) |=> (cap == CW'(MAX_EVENTS - 3 * STEP_EVENTS)));
endmodule

// File: rtl/ebuf_ptrs.sv
module ebuf_ptrs
  import ebuf_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_clr,
  input  logic          push,
  input  logic          pop,
  input  rd_dir_e       dir,
  input  logic [CW-1:0] cap,
  output logic [CW-1:0] wr_q,
  output logic [CW-1:0] rd_q,
  output logic [CW-1:0] fill_q,
  output logic [CW-1:0] fill_d,
  output logic          err_q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] wr_d, rd_d, last;
  logic          err_d, push_ok, pop_ok, wrap;

  always_comb begin
    last    = cap - CW'(1);
    push_ok = push && !buf_clr && (fill_q != cap);
    pop_ok  = pop && !buf_clr && (fill_q != '0);
    wrap    = (dir == RD_UP) ? (rd_q == last) : (rd_q == '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    err_d   = err_q;
    fill_d  = fill_q;
    if (buf_clr) begin
      wr_d   = '0;
      rd_d   = '0;
      err_d  = 1'b0;
      fill_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == last) ? '0 : wr_q + CW'(1);
      if (pop_ok) begin
        err_d = wrap;
        if (dir == RD_UP) rd_d = wrap ? '0 : rd_q + CW'(1);
        else              rd_d = wrap ? last : rd_q - CW'(1);
      end
      case ({push_ok, pop_ok})
        2'b10:   fill_d = fill_q + CW'(1);
        2'b01:   fill_d = fill_q - CW'(1);
        default: fill_d = fill_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      err_q  <= err_d;
      fill_q <= fill_d;
    end
  end

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= cap);
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !buf_clr && fill_q == cap) |=> $stable(fill_q));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> (fill_q == '0 && wr_q == '0 && rd_q == '0 && !err_q));
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q < cap);
  p_down_wrap_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !buf_clr && fill_q != '0 && dir == RD_DOWN && rd_q == '0) |=> (err_q && rd_q == $past(last)));
endmodule

// File: rtl/ebuf_alarm.sv
module ebuf_alarm
  import ebuf_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               buf_clr,
  input  logic [CW-1:0]      cap,
  input  logic [CW-1:0]      fill_q,
  input  logic [CW-1:0]      fill_d,
  input  logic [N_ALARM-1:0] ien,
  input  logic [N_ALARM-1:0] iclr,
  output logic [N_ALARM-1:0] pend_q,
  output logic               irq_n
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW+1:0]      cap3;
  logic [CW-1:0]      thr [N_ALARM];
  logic [N_ALARM-1:0] pend_d, enter;

  always_comb begin
    cap3          = ({2'b00, cap} << 1) + {2'b00, cap};
    thr[AL_HALF]  = cap >> 1;
    thr[AL_3Q]    = CW'(cap3 >> 2);
    thr[AL_FULL]  = cap;
  end

  for (genvar i = 0; i < N_ALARM; i++) begin : g_al
    always_comb begin
      enter[i]  = (fill_q < thr[i]) && (fill_d >= thr[i]);
      pend_d[i] = pend_q[i];
      if (buf_clr)                pend_d[i] = 1'b0;
      else if (ien[i] && enter[i]) pend_d[i] = 1'b1;
      else if (iclr[i])           pend_d[i] = 1'b0;
    end

    p_need_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(ien[i]));
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iclr[i] && !(ien[i] && enter[i])) |=> !pend_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq_n = ~|pend_q;
endmodule

// File: rtl/ebuf_mgr.sv
module ebuf_mgr
  import ebuf_pkg::*;
#(
  parameter int MAX_EVENTS   = 4000,
  parameter int STEP_EVENTS  = 1000,
  parameter int USER_KB_STEP = 8,
  localparam int CW          = $clog2(MAX_EVENTS + 1),
  localparam int KB_W        = $clog2(3 * USER_KB_STEP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [1:0]         ctl_size,
  input  logic               ctl_dir,
  input  logic               ien_we,
  input  logic [2:0]         ien_wdata,
  input  logic [2:0]         irq_clr,
  input  logic               evt_push,
  input  logic               evt_pop,
  output logic [CW-1:0]      wr_addr,
  output logic [CW-1:0]      rd_addr,
  output logic [CW-1:0]      fill,
  output logic [CW-1:0]      capacity,
  output logic [KB_W-1:0]    user_kb,
  output logic               rd_err,
  output logic [2:0]         irq_pend,
  output logic               irq_n
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0]         rst_sync;
  logic               core_rst_n, buf_clr;
  rd_dir_e            dir_q;
  logic [N_ALARM-1:0] ien_q;
  logic [CW-1:0]      fill_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  ebuf_cfg #(
    .MAX_EVENTS(MAX_EVENTS), .STEP_EVENTS(STEP_EVENTS),
    .USER_KB_STEP(USER_KB_STEP), .CW(CW), .KB_W(KB_W)
  ) u_cfg (
    .clk(clk), .rst_n(core_rst_n), .ctl_we(ctl_we), .ctl_size(ctl_size),
    .ctl_dir(ctl_dir), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .dir_q(dir_q), .ien_q(ien_q), .buf_clr(buf_clr), .cap(capacity),
    .user_kb(user_kb)
  );

  ebuf_ptrs #(.CW(CW)) u_ptrs (
    .clk(clk), .rst_n(core_rst_n), .buf_clr(buf_clr), .push(evt_push),
    .pop(evt_pop), .dir(dir_q), .cap(capacity), .wr_q(wr_addr),
    .rd_q(rd_addr), .fill_q(fill), .fill_d(fill_d), .err_q(rd_err)
  );

  ebuf_alarm #(.CW(CW)) u_alarm (
    .clk(clk), .rst_n(core_rst_n), .buf_clr(buf_clr), .cap(capacity),
    .fill_q(fill), .fill_d(fill_d), .ien(ien_q), .iclr(irq_clr),
    .pend_q(irq_pend), .irq_n(irq_n)
  );
endmodule

// File: tb/ebuf_mgr_test.sv
module ebuf_mgr_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we, ctl_dir, ien_we, evt_push, evt_pop;
  logic [1:0]  ctl_size;
  logic [2:0]  ien_wdata, irq_clr;
  logic [11:0] wr_addr, rd_addr, fill, capacity;
  logic [4:0]  user_kb;
  logic        rd_err, irq_n;
  logic [2:0]  irq_pend;

  int checks = 0;
  int failures = 0;
  logic [1:0] size_sh = 2'b00;
  logic       dir_sh = 1'b0;

  always #2 clk = ~clk;

  ebuf_mgr uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_size(ctl_size),
    .ctl_dir(ctl_dir), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .irq_clr(irq_clr), .evt_push(evt_push), .evt_pop(evt_pop),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .fill(fill), .capacity(capacity),
    .user_kb(user_kb), .rd_err(rd_err), .irq_pend(irq_pend), .irq_n(irq_n)
  );

  function automatic int cap_of(int c);
    return 4000 - 1000 * c;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ctl_we = 0; ien_we = 0; irq_clr = 0; evt_push = 0; evt_pop = 0;
    ctl_size = size_sh; ctl_dir = dir_sh; ien_wdata = 0;
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin
      evt_push = 1; @(negedge clk); evt_push = 0;
    end
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) begin
      evt_pop = 1; @(negedge clk); evt_pop = 0;
    end
  endtask

  task automatic ctl_write(logic [1:0] s, logic d);
    size_sh = s; dir_sh = d;
    ctl_size = s; ctl_dir = d; ctl_we = 1;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic set_ien(logic [2:0] v);
    ien_wdata = v; ien_we = 1; @(negedge clk); ien_we = 0;
  endtask

  task automatic ack(logic [2:0] v);
    irq_clr = v; @(negedge clk); irq_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "wr_addr", wr_addr, 0);
    chk("R1", "rd_addr", rd_addr, 0);
    chk("R1", "fill", fill, 0);
    chk("R1", "capacity", capacity, 4000);
    chk("R1", "user_kb", user_kb, 0);
    chk("R1", "rd_err", rd_err, 0);
    chk("R1", "irq_pend", irq_pend, 0);
    chk("R1", "irq_n", irq_n, 1);
  endtask

  task automatic t_sizes();
    for (int c = 1; c < 5; c++) begin
      ctl_write(2'(c % 4), 0);
      chk("R2", "capacity", capacity, cap_of(c % 4));
      chk("R2", "user_kb", user_kb, 8 * (c % 4));
    end
  endtask

  task automatic t_resize();
    ctl_write(2'b11, 0);
    push_n(5);
    chk("R4", "fill after 5 pushes", fill, 5);
    chk("R4", "wr_addr after 5 pushes", wr_addr, 5);
    ctl_write(2'b11, 0);
    chk("R3", "fill kept on same code", fill, 5);
    chk("R3", "wr_addr kept on same code", wr_addr, 5);
    evt_push = 1; ctl_write(2'b10, 0); evt_push = 0;
    chk("R3", "fill cleared on new code", fill, 0);
    chk("R3", "wr_addr cleared", wr_addr, 0);
    chk("R3", "capacity", capacity, 2000);
  endtask

  task automatic t_push_pop();
    ctl_write(2'b11, 0);
    push_n(3);
    pop_n(1);
    chk("R6", "rd_addr up", rd_addr, 1);
    chk("R6", "fill after pop", fill, 2);
    evt_push = 1; evt_pop = 1; @(negedge clk); evt_push = 0; evt_pop = 0;
    chk("R10", "fill on push+pop", fill, 2);
    chk("R10", "wr_addr on push+pop", wr_addr, 4);
    chk("R10", "rd_addr on push+pop", rd_addr, 2);
    ctl_write(2'b11, 1);
    pop_n(1);
    chk("R6", "rd_addr down", rd_addr, 1);
    pop_n(1);
    chk("R6", "fill empty", fill, 0);
    pop_n(1);
    chk("R6", "rd_addr on empty pop", rd_addr, 0);
    chk("R6", "fill on empty pop", fill, 0);
    chk("R7", "rd_err no wrap", rd_err, 0);
  endtask

  task automatic t_err();
    ctl_write(2'b10, 1); ctl_write(2'b11, 1);
    push_n(1); pop_n(1);
    chk("R7", "rd_addr down wrap", rd_addr, 999);
    chk("R7", "rd_err down wrap", rd_err, 1);
    push_n(1); pop_n(1);
    chk("R7", "rd_addr after step", rd_addr, 998);
    chk("R7", "rd_err cleared", rd_err, 0);
    ctl_write(2'b10, 0); ctl_write(2'b11, 0);
    push_n(1000);
    chk("R4", "fill at full", fill, 1000);
    chk("R4", "wr_addr wrapped", wr_addr, 0);
    push_n(1);
    chk("R5", "fill on dropped push", fill, 1000);
    chk("R5", "wr_addr on dropped push", wr_addr, 0);
    pop_n(999);
    chk("R7", "rd_err before wrap", rd_err, 0);
    pop_n(1);
    chk("R7", "rd_addr up wrap", rd_addr, 0);
    chk("R7", "rd_err up wrap", rd_err, 1);
    ctl_write(2'b10, 0);
    chk("R3", "rd_err cleared by new code", rd_err, 0);
  endtask

  task automatic t_alarm();
    ctl_write(2'b11, 0);
    set_ien(3'b101);
    push_n(499);
    chk("R8", "no alarm below half", irq_pend, 0);
    chk("R9", "irq_n idle", irq_n, 1);
    push_n(1);
    chk("R8", "half alarm", irq_pend, 3'b001);
    chk("R9", "irq_n asserted", irq_n, 0);
    push_n(250);
    chk("R8", "three-quarter disabled", irq_pend, 3'b001);
    ack(3'b001);
    chk("R9", "ack clears", irq_pend, 0);
    chk("R9", "irq_n released", irq_n, 1);
    push_n(1);
    chk("R8", "no relatch in region", irq_pend, 0);
    push_n(249);
    chk("R8", "full alarm", irq_pend, 3'b100);
    set_ien(3'b111);
    pop_n(251);
    chk("R8", "alarms held on drain", irq_pend, 3'b100);
    push_n(1);
    chk("R8", "three-quarter latched", irq_pend, 3'b110);
    ctl_write(2'b10, 0);
    chk("R3", "alarms cleared by new code", irq_pend, 0);
    chk("R3", "irq_n after new code", irq_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sizes();
    t_resize();
    t_push_pop();
    t_err();
    t_alarm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule